// File: doc/BRIEF.md
# SPI Master with Automatic Read-After-Command Mode

The block is an SPI master with a transmit FIFO and a receive FIFO. It has two operating modes. In duplex mode, every frame taken from the transmit FIFO is shifted out on MOSI. The frame shifted in on MISO at the same time is stored in the receive FIFO. The transfer ends when the transmit FIFO runs dry.

In serial-memory read mode, software first pushes an opcode, address bytes and dummy bytes into the transmit FIFO, then issues a start strobe. The controller shifts those frames out and stores nothing they return. When the transmit FIFO is empty, the controller moves into a read phase on its own. In that phase it holds MOSI at a fixed level and clocks in a programmed number of frames. Chip select stays low for the whole sequence. The configuration is held in registers that persist, so the same read can be repeated by pushing only the command frames again.

SCLK uses mode 0 timing: it idles low, MOSI changes after the falling edge and MISO is sampled at the rising edge. Each SCLK half-period is `cfg_half_div + 1` system clocks, so the SCLK period is always an even number of clocks. The controller is built as a six-state machine:

- `ST_IDLE` (CS high). On `start` it goes to `ST_LOAD`.
- `ST_LOAD` fetches the next frame. With command data it goes to `ST_LOW`. When a read frame is still owed it also goes to `ST_LOW`. Otherwise it goes to `ST_FINISH`.
- `ST_LOW` (SCLK low) goes to `ST_HIGH` when its half-period expires, and samples MISO on that transition.
- `ST_HIGH` (SCLK high) goes back to `ST_LOW` for the next bit, or to `ST_STORE` after the last bit of the frame.
- `ST_STORE` writes or drops the captured frame, then goes to `ST_LOAD`.
- `ST_FINISH` (CS high, done pulse) goes to `ST_IDLE`.

Top module: `spi_eeprom_master`

## Requirements
- R1: After reset, cs_n=1, sclk=0, busy=0, done=0, rx_overflow=0, and both FIFOs report empty.
- R2: In duplex mode (cfg_eeprom_mode=0), each transmit frame is shifted out MSB first. The frame shifted in at the same time is written to the receive FIFO. The transfer ends when the transmit FIFO is empty.
- R3: In read mode (cfg_eeprom_mode=1), the frames in the transmit FIFO are shifted out first, and none of the frames shifted in during that command phase reach the receive FIFO.
- R4: In read mode, the read phase starts without any software action when the transmit FIFO is empty. This includes the case where it is already empty at start. The read phase clocks exactly cfg_read_count frames, with MOSI held at the IDLE_MOSI level (0 by default), and every frame goes to the receive FIFO.
- R5: A read count of zero ends the transfer right after the command frames.
- R6: cs_n falls exactly once per transfer and stays low from the first command bit to the last read frame. busy is high whenever cs_n is low. done is a single-cycle pulse, given in the cycle cs_n returns high.
- R7: A frame that completes while the receive FIFO is full is dropped, and rx_overflow is set. rx_overflow stays set until the next accepted start clears it.
- R8: Configuration registers are loaded by cfg_we only while busy=0. A cfg_we during a transfer is ignored. Values persist across transfers.
- R9: SCLK idles low. Each high phase and each low phase lasts cfg_half_div+1 clocks. MOSI is stable while SCLK is high.
- R10: cfg_frame_bits holds the frame length minus one. Received frames are right-aligned and zero-extended in rx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the configuration fields |
| cfg_eeprom_mode | input | 1 | 0 = duplex, 1 = command then read |
| cfg_frame_bits | input | FBW | Frame length minus one |
| cfg_read_count | input | CNT_W | Number of frames in the read phase |
| cfg_half_div | input | DIV_W | SCLK half-period minus one, in clocks |
| start | input | 1 | Starts a transfer when idle |
| tx_push | input | 1 | Write strobe for the transmit FIFO |
| tx_data | input | DATA_W | Transmit frame, right-aligned |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Removes the head of the receive FIFO |
| rx_data | output | DATA_W | Head of the receive FIFO |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_overflow | output | 1 | Sticky flag: a frame was dropped |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Slave data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench acts as a slave model and records every MOSI bit and every SCLK rising edge. This catches a read phase that runs one frame too many or too few, and a command phase whose echoes leak into the receive FIFO as extra entries.

The corner cases each get their own test:
- A transmit FIFO that is already empty at start, which a wrong design would end at once instead of reading.
- A zero read count, which a wrong design would treat as a count of 65536.
- A write to the receive FIFO while it is full, where a wrong design would overwrite stored data or lose the sticky flag.
- A configuration write while busy, which would change the count of a later read.

Counting chip-select falling edges exposes any deassertion between the command and read phases. 4-bit frames and a wider divider check frame-length and SCLK timing.

// File: rtl/spi_er_pkg.sv
package spi_er_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_STORE,
        ST_FINISH
    } ctl_state_t;

    typedef enum logic [1:0] {
        PH_DUPLEX,
        PH_CMD,
        PH_READ
    } phase_t;

endpackage

// File: rtl/spi_er_fifo.sv
module spi_er_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_er_cfg.sv
module spi_er_cfg #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 8,
    localparam int FBW   = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             busy,
    input  logic             eeprom_mode_in,
    input  logic [FBW-1:0]   frame_bits_in,
    input  logic [CNT_W-1:0] read_count_in,
    input  logic [DIV_W-1:0] half_div_in,
    output logic             eeprom_mode,
    output logic [FBW-1:0]   frame_bits,
    output logic [CNT_W-1:0] read_count,
    output logic [DIV_W-1:0] half_div
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eeprom_mode <= 1'b0;
            frame_bits  <= FBW'(DATA_W - 1);
            read_count  <= '0;
            half_div    <= '0;
        end else if (we && !busy) begin
            eeprom_mode <= eeprom_mode_in;
            frame_bits  <= frame_bits_in;
            read_count  <= read_count_in;
            half_div    <= half_div_in;
        end
    end
endmodule

// File: rtl/spi_er_ctrl.sv
module spi_er_ctrl
    import spi_er_pkg::*;
#(
    parameter int   DATA_W    = 8,
    parameter int   CNT_W     = 16,
    parameter int   DIV_W     = 8,
    parameter logic IDLE_MOSI = 1'b0,
    localparam int  FBW       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              eeprom_mode,
    input  logic [FBW-1:0]    frame_bits,
    input  logic [CNT_W-1:0]  read_count,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_rdata,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_wdata,
    output logic              rx_overflow,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    ctl_state_t        state_q, state_d;
    phase_t            phase_q;
    logic [DATA_W-1:0] tx_shift, rx_shift;
    logic [DIV_W-1:0]  div_cnt;
    logic [FBW-1:0]    bit_idx;
    logic [CNT_W-1:0]  remain;
    logic              half_up, cmd_avail, read_owed;

    assign half_up   = (div_cnt == half_div);
    assign cmd_avail = !tx_empty && (phase_q != PH_READ);
    assign read_owed = eeprom_mode && (remain != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_LOAD;
            ST_LOAD: begin
                if (cmd_avail || read_owed) state_d = ST_LOW;
                else                        state_d = ST_FINISH;
            end
            ST_LOW:    if (half_up) state_d = ST_HIGH;
            ST_HIGH: begin
                if (half_up)
                    state_d = (bit_idx == frame_bits) ? ST_STORE : ST_LOW;
            end
            ST_STORE:  state_d = ST_LOAD;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        cs_n    = 1'b1;
        sclk    = 1'b0;
        mosi    = IDLE_MOSI;
        busy    = 1'b1;
        done    = 1'b0;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_LOAD: begin
                cs_n   = 1'b0;
                tx_pop = cmd_avail;
            end
            ST_LOW: begin
                cs_n = 1'b0;
                mosi = tx_shift[frame_bits];
            end
            ST_HIGH: begin
                cs_n = 1'b0;
                sclk = 1'b1;
                mosi = tx_shift[frame_bits];
            end
            ST_STORE: begin
                cs_n    = 1'b0;
                rx_push = (phase_q != PH_CMD) && !rx_full;
            end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign rx_wdata = rx_shift;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q     <= PH_DUPLEX;
            tx_shift    <= '0;
            rx_shift    <= '0;
            div_cnt     <= '0;
            bit_idx     <= '0;
            remain      <= '0;
            rx_overflow <= 1'b0;
        end else begin
            div_cnt <= (state_d != state_q) ? '0 : div_cnt + 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        remain      <= read_count;
                        rx_overflow <= 1'b0;
                        phase_q     <= PH_DUPLEX;
                    end
                end
                ST_LOAD: begin
                    rx_shift <= '0;
                    bit_idx  <= '0;
                    if (cmd_avail) begin
                        tx_shift <= tx_rdata;
                        phase_q  <= eeprom_mode ? PH_CMD : PH_DUPLEX;
                    end else if (read_owed) begin
                        tx_shift <= {DATA_W{IDLE_MOSI}};
                        phase_q  <= PH_READ;
                    end
                end
                ST_LOW: begin
                    if (half_up) rx_shift <= {rx_shift[DATA_W-2:0], miso};
                end
                ST_HIGH: begin
                    if (half_up && (bit_idx != frame_bits)) begin
                        tx_shift <= {tx_shift[DATA_W-2:0], IDLE_MOSI};
                        bit_idx  <= bit_idx + 1'b1;
                    end
                end
                ST_STORE: begin
                    if ((phase_q != PH_CMD) && rx_full) rx_overflow <= 1'b1;
                    if (phase_q == PH_READ) remain <= remain - 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_eeprom_master.sv
module spi_eeprom_master #(
    parameter int   DATA_W    = 8,
    parameter int   TX_DEPTH  = 4,
    parameter int   RX_DEPTH  = 4,
    parameter int   CNT_W     = 16,
    parameter int   DIV_W     = 8,
    parameter logic IDLE_MOSI = 1'b0,
    localparam int  FBW       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_eeprom_mode,
    input  logic [FBW-1:0]    cfg_frame_bits,
    input  logic [CNT_W-1:0]  cfg_read_count,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic              start,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_overflow,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    logic              mode_r;
    logic [FBW-1:0]    fbits_r;
    logic [CNT_W-1:0]  count_r;
    logic [DIV_W-1:0]  div_r;
    logic [DATA_W-1:0] tx_head, rx_in;
    logic              tx_pop_w, rx_push_w;

    spi_er_cfg #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .busy(busy),
        .eeprom_mode_in(cfg_eeprom_mode), .frame_bits_in(cfg_frame_bits),
        .read_count_in(cfg_read_count), .half_div_in(cfg_half_div),
        .eeprom_mode(mode_r), .frame_bits(fbits_r),
        .read_count(count_r), .half_div(div_r)
    );

    spi_er_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
        .pop(tx_pop_w), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_er_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push_w), .wdata(rx_in),
        .pop(rx_pop), .rdata(rx_data), .full(rx_full), .empty(rx_empty)
    );

    spi_er_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W),
                  .IDLE_MOSI(IDLE_MOSI)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .eeprom_mode(mode_r), .frame_bits(fbits_r),
        .read_count(count_r), .half_div(div_r),
        .tx_empty(tx_empty), .tx_rdata(tx_head), .tx_pop(tx_pop_w),
        .rx_full(rx_full), .rx_push(rx_push_w), .rx_wdata(rx_in),
        .rx_overflow(rx_overflow), .busy(busy), .done(done),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );
endmodule

// File: rtl/spi_er_checks.sv
module spi_er_checks (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic done,
    input logic rx_overflow
);
    assert_sclk_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_stable_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_busy_while_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && busy) |=> rx_overflow);
endmodule

bind spi_eeprom_master spi_er_checks u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .busy(busy), .done(done), .rx_overflow(rx_overflow)
);

// File: tb/spi_eeprom_master_bench.sv
`timescale 1ns/1ps
module spi_eeprom_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_mode = 1'b0;
    logic [2:0] cfg_fb = 3'd7;
    logic [15:0] cfg_cnt = '0;
    logic [7:0] cfg_div = '0;
    logic       start = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_full, tx_empty, rx_full, rx_empty, rx_overflow;
    logic [7:0] rx_data;
    logic       busy, done, sclk, mosi, cs_n;
    logic       miso = 1'b0;

    int total = 0, bad = 0;
    logic [0:511] miso_stream;
    logic [0:511] mosi_cap;
    int s_idx = 0, m_cnt = 0, cs_falls = 0, done_cnt = 0;
    int hi_cyc = 0, cs_low_cyc = 0;

    always #2 clk = ~clk;

    spi_eeprom_master u_spi_eeprom_master (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_eeprom_mode(cfg_mode),
        .cfg_frame_bits(cfg_fb), .cfg_read_count(cfg_cnt), .cfg_half_div(cfg_div),
        .start(start), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_overflow(rx_overflow), .busy(busy), .done(done),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // slave model
    always @(negedge cs_n) begin
        s_idx = 0;
        miso = miso_stream[0];
        cs_falls++;
    end
    always @(negedge sclk) if (!cs_n && s_idx < 511) begin
        s_idx++;
        miso = miso_stream[s_idx];
    end
    always @(posedge sclk) if (m_cnt < 512) begin
        mosi_cap[m_cnt] = mosi;
        m_cnt++;
    end
    always @(posedge clk) begin
        if (done) done_cnt++;
        if (sclk) hi_cyc++;
        if (!cs_n) cs_low_cyc++;
    end

    initial begin
        #600000;
        bad++; total++;
        $display("FAIL watchdog: act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic m, input logic [2:0] fb, input logic [15:0] c,
                           input logic [7:0] d);
        @(negedge clk);
        cfg_mode = m; cfg_fb = fb; cfg_cnt = c; cfg_div = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge clk);
        tx_data = v; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic set_frame(input int idx, input int fw, input logic [7:0] v);
        for (int b = 0; b < fw; b++) miso_stream[idx*fw + b] = v[fw-1-b];
    endtask

    function automatic logic [7:0] cap_frame(input int idx, input int fw);
        logic [7:0] r = '0;
        for (int b = 0; b < fw; b++) r = {r[6:0], mosi_cap[idx*fw + b]};
        return r;
    endfunction

    task automatic run();
        m_cnt = 0; cs_falls = 0; done_cnt = 0; hi_cyc = 0; cs_low_cyc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic expect_rx(input string req, input logic [7:0] exp);
        check(!rx_empty && rx_data == exp, req, rx_empty ? 'hEE : int'(rx_data), exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic t_reset();
        check(cs_n && !sclk && !busy && !done, "R1 pins", {cs_n, sclk, busy, done}, 4'b1000);
        check(tx_empty && rx_empty && !rx_overflow, "R1 flags",
              {tx_empty, rx_empty, rx_overflow}, 3'b110);
    endtask

    task automatic t_duplex();
        set_cfg(1'b0, 3'd7, 16'd0, 8'd1);
        miso_stream = '0;
        set_frame(0, 8, 8'h5A); set_frame(1, 8, 8'hC3);
        push(8'hA5); push(8'h3C);
        run();
        check(m_cnt == 16, "R2 edges", m_cnt, 16);
        check(cap_frame(0, 8) == 8'hA5 && cap_frame(1, 8) == 8'h3C, "R2 mosi",
              {cap_frame(0, 8), cap_frame(1, 8)}, 16'hA53C);
        expect_rx("R2 rx0", 8'h5A);
        expect_rx("R2 rx1", 8'hC3);
        check(rx_empty, "R2 rx count", rx_empty, 1);
        check(done_cnt == 1 && cs_falls == 1, "R6 duplex", {done_cnt, cs_falls}, 'h100000001);
    endtask

    task automatic t_read(input string tag);
        miso_stream = '0;
        set_frame(0, 8, 8'hFF); set_frame(1, 8, 8'hEE);
        set_frame(2, 8, 8'hDD); set_frame(3, 8, 8'hCC);
        set_frame(4, 8, 8'h11); set_frame(5, 8, 8'h22); set_frame(6, 8, 8'h33);
        push(8'h03); push(8'h12); push(8'h34); push(8'h00);
        run();
        check(m_cnt == 56, {"R4 edges ", tag}, m_cnt, 56);
        check(cap_frame(0, 8) == 8'h03 && cap_frame(2, 8) == 8'h34, {"R3 cmd out ", tag},
              {cap_frame(0, 8), cap_frame(2, 8)}, 16'h0334);
        check(cap_frame(4, 8) == 0 && cap_frame(5, 8) == 0 && cap_frame(6, 8) == 0,
              {"R4 mosi level ", tag}, {cap_frame(4, 8), cap_frame(5, 8), cap_frame(6, 8)}, 0);
        check(cs_falls == 1 && done_cnt == 1, {"R6 single cs ", tag}, cs_falls, 1);
        expect_rx({"R3 first rx is read data ", tag}, 8'h11);
        expect_rx({"R4 rx1 ", tag}, 8'h22);
        expect_rx({"R4 rx2 ", tag}, 8'h33);
        check(rx_empty, {"R3 no cmd echo ", tag}, rx_empty, 1);
    endtask

    task automatic t_zero_count();
        set_cfg(1'b1, 3'd7, 16'd0, 8'd1);
        miso_stream = '0;
        push(8'h9F); push(8'h01);
        run();
        check(m_cnt == 16, "R5 edges", m_cnt, 16);
        check(rx_empty && done_cnt == 1, "R5 rx empty", rx_empty, 1);
    endtask

    task automatic t_empty_tx();
        set_cfg(1'b1, 3'd7, 16'd2, 8'd1);
        miso_stream = '0;
        set_frame(0, 8, 8'h6B); set_frame(1, 8, 8'h7C);
        run();
        check(m_cnt == 16, "R4 empty tx edges", m_cnt, 16);
        expect_rx("R4 empty tx rx0", 8'h6B);
        expect_rx("R4 empty tx rx1", 8'h7C);
    endtask

    task automatic t_overflow();
        set_cfg(1'b1, 3'd7, 16'd6, 8'd1);
        miso_stream = '0;
        for (int i = 1; i <= 6; i++) set_frame(i, 8, 8'h80 + 8'(i));
        push(8'h0B);
        run();
        check(m_cnt == 56, "R7 edges", m_cnt, 56);
        check(rx_overflow && rx_full, "R7 flag", {rx_overflow, rx_full}, 2'b11);
        for (int i = 1; i <= 4; i++) expect_rx("R7 kept frames", 8'h80 + 8'(i));
        check(rx_empty && rx_overflow, "R7 dropped and sticky", {rx_empty, rx_overflow}, 2'b11);
        set_cfg(1'b1, 3'd7, 16'd1, 8'd1);
        set_frame(0, 8, 8'h42);
        run();
        check(!rx_overflow, "R7 cleared by start", rx_overflow, 0);
        expect_rx("R7 after clear", 8'h42);
    endtask

    task automatic t_busy_cfg();
        set_cfg(1'b1, 3'd7, 16'd2, 8'd1);
        miso_stream = '0;
        m_cnt = 0; cs_falls = 0; done_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        cfg_cnt = 16'd5; cfg_mode = 1'b0; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
        for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
        @(negedge clk);
        check(m_cnt == 16, "R8 busy write ignored", m_cnt, 16);
        expect_rx("R8 d0", 8'h00); expect_rx("R8 d1", 8'h00);
        run();
        check(m_cnt == 16, "R8 kept count", m_cnt, 16);
        expect_rx("R8 d2", 8'h00); expect_rx("R8 d3", 8'h00);
    endtask

    task automatic t_nibble();
        set_cfg(1'b1, 3'd3, 16'd3, 8'd1);
        miso_stream = '0;
        set_frame(0, 4, 8'h5); set_frame(1, 4, 8'h9);
        set_frame(2, 4, 8'h6); set_frame(3, 4, 8'hF);
        push(8'h0A);
        run();
        check(m_cnt == 16, "R10 edges", m_cnt, 16);
        check(cap_frame(0, 4) == 8'hA && cap_frame(1, 4) == 0, "R10 mosi",
              cap_frame(0, 4), 'hA);
        expect_rx("R10 rx0", 8'h09);
        expect_rx("R10 rx1", 8'h06);
        expect_rx("R10 rx2", 8'h0F);
    endtask

    task automatic t_divider();
        set_cfg(1'b0, 3'd7, 16'd0, 8'd2);
        miso_stream = '0;
        set_frame(0, 8, 8'hAA);
        push(8'h55);
        run();
        check(hi_cyc == 24, "R9 high clocks", hi_cyc, 24);
        check(cs_low_cyc == 51, "R9 frame clocks", cs_low_cyc, 51);
        check(cap_frame(0, 8) == 8'h55, "R9 mosi", cap_frame(0, 8), 'h55);
        expect_rx("R9 rx", 8'hAA);
    endtask

    initial begin
        miso_stream = '0;
        mosi_cap = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_duplex();
        set_cfg(1'b1, 3'd7, 16'd3, 8'd1);
        t_read("first");
        t_read("repeat");
        t_zero_count();
        t_empty_tx();
        t_overflow();
        t_busy_cfg();
        t_nibble();
        t_divider();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule